// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside the program sequencer of a small processor core and runs hardware loops without spending any cycles on loop control. A block loop is armed by a loop command that carries an iteration count and the address of the body's last instruction. The body begins at the address after the command. Whenever the instruction at that last address executes and more passes remain, the controller selects the loop start as the next PC in that same cycle. A repeat command makes the one instruction that follows it execute a programmed number of times. It does this by holding the instruction fetch. A repeat may sit inside a running block loop, including on the loop's last instruction.

The controller also gates interrupt entry. A request is granted unless a repeat is being armed or is still in progress. While the service routine runs, the block-loop state is frozen. Execution then resumes the loop with its count and addresses intact. Decode, datapath and memory stay outside. The core tells the block which instruction executes in each cycle (`valid_i`, `pc_i`) and acts on the next-PC select and the target address the block returns.

Top module: `hwl_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `do_active_o`, `rep_active_o`, `fetch_hold_o` and `irq_take_o` are 0, and `npc_sel_o` is 0 (sequential) with `target_o` = `pc_i`+1.
- R2: A loop command is accepted only in a cycle with `valid_i`=1. When accepted with a nonzero count, it arms the loop with start = `pc_i`+1, and `do_active_o` rises after that clock edge. With `valid_i`=0 the command has no effect.
- R3: When an armed loop is at its last address with more than one pass left, `npc_sel_o`=1 (loop back) and `target_o` = the loop start in the same cycle. One pass is consumed at the clock edge.
- R4: On the final pass at the last address, `npc_sel_o`=0 and `target_o` = last address + 1, and `do_active_o` falls after the edge. A body with count N runs exactly N times, and N=1 runs it once.
- R5: A loop command with count 0 drives `npc_sel_o`=2 (skip) and `target_o` = given last address + 1 in its own cycle. It leaves `do_active_o` unchanged.
- R6: A repeat command with count N≥2 makes the next instruction execute N times. `fetch_hold_o` is 1 for its first N−1 valid cycles and 0 on the last. `rep_active_o` is 1 from the edge after the command until the edge after the last execution.
- R7: A repeat count of 1 or 0 never raises `fetch_hold_o`, and the instruction runs once.
- R8: A repeat on the loop's last instruction leaves the block loop alone until the last repetition. Only then is the loop-back or exit decision taken, and the loop's pass count is unchanged by the repeat.
- R9: `irq_take_o` follows `irq_req_i`, except that it is 0 in the cycle of an accepted repeat command and while more than one repetition remains. The request is held pending until the last repetition.
- R10: From the grant until an `irq_ret_i` cycle, no further grant is given, last-address matches are ignored, and loop commands are ignored. Afterwards the loop continues with its count and addresses unchanged.
- R11: If a loop command and a repeat command arrive in the same valid cycle, only the loop command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction executes this cycle |
| pc_i | input | AW | Address of the executing instruction |
| do_start_i | input | 1 | Executing instruction is a loop command |
| do_count_i | input | CW | Loop pass count |
| do_end_i | input | AW | Address of the loop body's last instruction |
| rep_start_i | input | 1 | Executing instruction is a repeat command |
| rep_count_i | input | CW | Repeat count |
| irq_req_i | input | 1 | Interrupt request pending |
| irq_ret_i | input | 1 | Return from interrupt service executes |
| npc_sel_o | output | 2 | Next PC: 0 sequential, 1 loop start, 2 skip past body |
| target_o | output | AW | Next PC address for the current select |
| fetch_hold_o | output | 1 | Hold the fetch; re-execute the current instruction |
| do_active_o | output | 1 | A block loop is armed |
| rep_active_o | output | 1 | A repeat is armed or in progress |
| irq_take_o | output | 1 | Interrupt entry granted this cycle |

## Verification
The select, target, fetch hold and interrupt grant depend on the present inputs and the registered loop state, so each is due in the very cycle of its stimulus. The two activity flags and every count change appear only after the following rising edge. The bench applies each trace step at the falling edge and samples the combinational results 1 ns later, before the next rising edge. It expects the flags to show each step's effect in the next step's sample. Repeats, interrupt entry and return inside a loop are laid out as consecutive trace steps, so every count decrement is observed through the cycle in which the loop-back or exit select appears.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ  = 2'd0,
    NPC_LOOP = 2'd1,
    NPC_SKIP = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/hwl_do_unit.sv
module hwl_do_unit
  import hwl_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] pc_i,
  input  logic          in_isr_i,
  input  logic          hold_i,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] end_i,
  output npc_sel_e      sel_o,
  output logic [AW-1:0] target_o,
  output logic          active_o
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          act_q;
  logic [AW-1:0] start_q, end_q;
  logic [CW-1:0] cnt_q;
  logic          do_go, zero_cnt, at_end, more;

  assign do_go    = start_i & valid_i & ~in_isr_i;
  assign zero_cnt = (count_i == '0);
  // end match counts only on the last repetition and outside service
  assign at_end   = act_q & valid_i & ~hold_i & ~in_isr_i & ~do_go & (pc_i == end_q);
  assign more     = (cnt_q > CNT_ONE);

  always_comb begin
    sel_o    = NPC_SEQ;
    target_o = pc_i + ADDR_ONE;
    if (do_go && zero_cnt) begin
      sel_o    = NPC_SKIP;
      target_o = end_i + ADDR_ONE;
    end else if (at_end && more) begin
      sel_o    = NPC_LOOP;
      target_o = start_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
    end else if (do_go) begin
      if (!zero_cnt) begin
        act_q   <= 1'b1;
        start_q <= pc_i + ADDR_ONE;
        end_q   <= end_i;
        cnt_q   <= count_i;
      end
    end else if (at_end) begin
      if (more) cnt_q <= cnt_q - CNT_ONE;
      else      act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/hwl_rep_unit.sv
module hwl_rep_unit #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          go_i,
  input  logic [CW-1:0] count_i,
  output logic          hold_o,
  output logic          busy_o,
  output logic          active_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  assign busy_o   = (cnt_q > CNT_ONE);
  assign hold_o   = valid_i & busy_o;
  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (go_i)              cnt_q <= count_i;
    else if (valid_i && active_o) cnt_q <= cnt_q - CNT_ONE;
  end
endmodule

// File: rtl/hwl_irq_gate.sv
module hwl_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ret_i,
  input  logic block_i,
  output logic take_o,
  output logic in_isr_o
);
  logic in_isr_q;

  assign take_o   = req_i & ~in_isr_q & ~block_i;
  assign in_isr_o = in_isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     in_isr_q <= 1'b0;
    else if (take_o) in_isr_q <= 1'b1;
    else if (ret_i)  in_isr_q <= 1'b0;
  end
endmodule

// File: rtl/hwl_ctrl.sv
module hwl_ctrl
  import hwl_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] pc_i,
  input  logic          do_start_i,
  input  logic [CW-1:0] do_count_i,
  input  logic [AW-1:0] do_end_i,
  input  logic          rep_start_i,
  input  logic [CW-1:0] rep_count_i,
  input  logic          irq_req_i,
  input  logic          irq_ret_i,
  output logic [1:0]    npc_sel_o,
  output logic [AW-1:0] target_o,
  output logic          fetch_hold_o,
  output logic          do_active_o,
  output logic          rep_active_o,
  output logic          irq_take_o
);
  npc_sel_e sel;
  logic     rep_go, rep_busy, in_isr;

  // loop command wins over repeat in the same cycle
  assign rep_go = rep_start_i & valid_i & ~do_start_i;

  hwl_rep_unit #(.CW(CW)) u_rep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .go_i     (rep_go),
    .count_i  (rep_count_i),
    .hold_o   (fetch_hold_o),
    .busy_o   (rep_busy),
    .active_o (rep_active_o)
  );

  hwl_irq_gate u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (irq_req_i),
    .ret_i    (irq_ret_i),
    .block_i  (rep_go | rep_busy),
    .take_o   (irq_take_o),
    .in_isr_o (in_isr)
  );

  hwl_do_unit #(.AW(AW), .CW(CW)) u_do (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .pc_i     (pc_i),
    .in_isr_i (in_isr),
    .hold_i   (fetch_hold_o),
    .start_i  (do_start_i),
    .count_i  (do_count_i),
    .end_i    (do_end_i),
    .sel_o    (sel),
    .target_o (target_o),
    .active_o (do_active_o)
  );

  assign npc_sel_o = sel;
endmodule

// File: rtl/hwl_ctrl_chk.sv
module hwl_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       do_start_i,
  input logic       rep_start_i,
  input logic [1:0] npc_sel_o,
  input logic       fetch_hold_o,
  input logic       do_active_o,
  input logic       rep_active_o,
  input logic       irq_take_o,
  input logic       in_isr
);
  p_loop_armed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_o == 2'd1) |-> (do_active_o && !fetch_hold_o));

  p_loop_stays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_o == 2'd1) |=> do_active_o);

  p_skip_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (npc_sel_o == 2'd2) |-> (do_start_i && valid_i));

  p_hold_rep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hold_o |-> rep_active_o);

  p_rep_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_active_o && valid_i && !fetch_hold_o && !rep_start_i) |=> !rep_active_o);

  p_irq_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hold_o |-> !irq_take_o);

  p_irq_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> !irq_take_o);

  p_isr_no_loop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_isr |-> (npc_sel_o != 2'd1));
endmodule

bind hwl_ctrl hwl_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .do_start_i   (do_start_i),
  .rep_start_i  (rep_start_i),
  .npc_sel_o    (npc_sel_o),
  .fetch_hold_o (fetch_hold_o),
  .do_active_o  (do_active_o),
  .rep_active_o (rep_active_o),
  .irq_take_o   (irq_take_o),
  .in_isr       (in_isr)
);

// File: tb/tb_hwl_ctrl.sv
`timescale 1ns/1ps
module tb_hwl_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic        do_start_i = 1'b0;
  logic [15:0] do_count_i = '0;
  logic [15:0] do_end_i = '0;
  logic        rep_start_i = 1'b0;
  logic [15:0] rep_count_i = '0;
  logic        irq_req_i = 1'b0;
  logic        irq_ret_i = 1'b0;
  logic [1:0]  npc_sel_o;
  logic [15:0] target_o;
  logic        fetch_hold_o, do_active_o, rep_active_o, irq_take_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hwl_ctrl #(.AW(16), .CW(16)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pc_i(pc_i),
    .do_start_i(do_start_i), .do_count_i(do_count_i), .do_end_i(do_end_i),
    .rep_start_i(rep_start_i), .rep_count_i(rep_count_i),
    .irq_req_i(irq_req_i), .irq_ret_i(irq_ret_i),
    .npc_sel_o(npc_sel_o), .target_o(target_o), .fetch_hold_o(fetch_hold_o),
    .do_active_o(do_active_o), .rep_active_o(rep_active_o), .irq_take_o(irq_take_o)
  );

  typedef struct packed {
    logic        v;
    logic [15:0] pc;
    logic        ds;
    logic [15:0] dc;
    logic [15:0] de;
    logic        rs;
    logic [15:0] rc;
    logic        iq;
    logic        ir;
    logic [1:0]  sel;
    logic [15:0] tgt;
    logic        hold;
    logic        take;
    logic        edo;
    logic        erep;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  // v pc ds dc de rs rc iq ir | sel tgt hold take do rep | req
  localparam vec_t TBL [NV] = '{
    '{1, 10,1,3,12, 0,0, 0,0, 0,11, 0,0,0,0, 2},  // R2 loop x3, body 11..12
    '{1, 11,0,0,0,  0,0, 0,0, 0,12, 0,0,1,0, 2},
    '{1, 12,0,0,0,  0,0, 0,0, 1,11, 0,0,1,0, 3},  // R3 loop back
    '{1, 11,0,0,0,  0,0, 0,0, 0,12, 0,0,1,0, 3},
    '{1, 12,0,0,0,  0,0, 0,0, 1,11, 0,0,1,0, 3},
    '{1, 11,0,0,0,  0,0, 0,0, 0,12, 0,0,1,0, 3},
    '{1, 12,0,0,0,  0,0, 0,0, 0,13, 0,0,1,0, 4},  // R4 final pass falls through
    '{1, 13,0,0,0,  0,0, 0,0, 0,14, 0,0,0,0, 4},
    '{1, 14,1,0,20, 0,0, 0,0, 2,21, 0,0,0,0, 5},  // R5 count zero skip
    '{1, 21,0,0,0,  0,0, 0,0, 0,22, 0,0,0,0, 5},
    '{1, 22,0,0,0,  1,3, 1,0, 0,23, 0,0,0,0, 9},  // R9 blocked on repeat command
    '{1, 23,0,0,0,  0,0, 0,0, 0,24, 1,0,0,1, 6},  // R6 repeat x3
    '{1, 23,0,0,0,  0,0, 1,0, 0,24, 1,0,0,1, 9},  // R9 held while repeating
    '{1, 23,0,0,0,  0,0, 1,0, 0,24, 0,1,0,1, 9},  // R9 granted on last repetition
    '{1,100,0,0,0,  0,0, 1,0, 0,101,0,0,0,0,10},  // R10 no second grant
    '{1,101,0,0,0,  0,0, 0,1, 0,102,0,0,0,0,10},
    '{1, 24,0,0,0,  1,1, 0,0, 0,25, 0,0,0,0, 7},  // R7 repeat of one
    '{1, 25,0,0,0,  0,0, 0,0, 0,26, 0,0,0,1, 7},
    '{1, 26,0,0,0,  1,0, 0,0, 0,27, 0,0,0,0, 7},  // R7 repeat of zero
    '{1, 27,0,0,0,  0,0, 0,0, 0,28, 0,0,0,0, 7},
    '{1, 30,1,2,33, 0,0, 0,0, 0,31, 0,0,0,0, 2},  // loop x2, body 31..33
    '{1, 31,0,0,0,  0,0, 1,0, 0,32, 0,1,1,0,10},  // R10 interrupt mid body
    '{1, 33,1,0,40, 0,0, 0,0, 0,34, 0,0,1,0,10},  // R10 end match and command ignored
    '{1, 50,0,0,0,  0,0, 0,1, 0,51, 0,0,1,0,10},
    '{1, 32,0,0,0,  1,2, 0,0, 0,33, 0,0,1,0, 8},  // R8 repeat on last instruction
    '{1, 33,0,0,0,  0,0, 0,0, 0,34, 1,0,1,1, 8},
    '{1, 33,0,0,0,  0,0, 0,0, 1,31, 0,0,1,1, 8},
    '{1, 31,0,0,0,  0,0, 0,0, 0,32, 0,0,1,0, 8},
    '{1, 32,0,0,0,  1,2, 0,0, 0,33, 0,0,1,0, 8},
    '{1, 33,0,0,0,  0,0, 0,0, 0,34, 1,0,1,1, 8},
    '{1, 33,0,0,0,  0,0, 0,0, 0,34, 0,0,1,1, 8},
    '{1, 34,0,0,0,  0,0, 0,0, 0,35, 0,0,0,0, 8},
    '{0, 34,1,0,50, 1,4, 0,0, 0,35, 0,0,0,0, 2},  // R2 commands need valid
    '{1, 60,1,1,61, 0,0, 0,0, 0,61, 0,0,0,0, 4},  // R4 single pass
    '{1, 61,0,0,0,  0,0, 0,0, 0,62, 0,0,1,0, 4},
    '{1, 62,0,0,0,  0,0, 0,0, 0,63, 0,0,0,0, 4},
    '{1, 63,0,0,0,  0,0, 0,0, 0,64, 0,0,0,0, 4}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t e);
    valid_i = e.v; pc_i = e.pc;
    do_start_i = e.ds; do_count_i = e.dc; do_end_i = e.de;
    rep_start_i = e.rs; rep_count_i = e.rc;
    irq_req_i = e.iq; irq_ret_i = e.ir;
  endtask

  task automatic idle();
    valid_i = 0; pc_i = '0; do_start_i = 0; do_count_i = '0; do_end_i = '0;
    rep_start_i = 0; rep_count_i = '0; irq_req_i = 0; irq_ret_i = 0;
  endtask

  task automatic check_row(input vec_t e, input int idx);
    string r;
    r = $sformatf("R%0d", e.req);
    chk(npc_sel_o == e.sel, r, $sformatf("sel row %0d", idx), npc_sel_o, e.sel);
    chk(target_o == e.tgt, r, $sformatf("target row %0d", idx), target_o, e.tgt);
    chk(fetch_hold_o == e.hold, r, $sformatf("hold row %0d", idx), fetch_hold_o, e.hold);
    chk(irq_take_o == e.take, r, $sformatf("take row %0d", idx), irq_take_o, e.take);
    chk(do_active_o == e.edo, r, $sformatf("do_active row %0d", idx), do_active_o, e.edo);
    chk(rep_active_o == e.erep, r, $sformatf("rep_active row %0d", idx), rep_active_o, e.erep);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    pc_i = 16'd5;
    #1;
    // R1 values while in reset
    chk(npc_sel_o == 2'd0 && target_o == 16'd6, "R1", "sel/target in reset", target_o, 6);
    chk(!do_active_o && !rep_active_o && !fetch_hold_o && !irq_take_o, "R1",
        "flags in reset", {do_active_o, rep_active_o, fetch_hold_o, irq_take_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(!do_active_o && !rep_active_o, "R1", "flags after reset",
        {do_active_o, rep_active_o}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(TBL[i]);
      #1;
      check_row(TBL[i], i);
    end

    // R11 loop command wins over simultaneous repeat
    @(negedge clk_i);
    idle(); valid_i = 1; pc_i = 16'd80; do_start_i = 1; do_count_i = 16'd2;
    do_end_i = 16'd81; rep_start_i = 1; rep_count_i = 16'd3;
    #1;
    chk(fetch_hold_o == 1'b0, "R11", "hold in command cycle", fetch_hold_o, 0);
    @(negedge clk_i);
    idle(); valid_i = 1; pc_i = 16'd81;
    #1;
    chk(rep_active_o == 1'b0, "R11", "repeat not armed", rep_active_o, 0);
    chk(fetch_hold_o == 1'b0, "R11", "no hold on next instr", fetch_hold_o, 0);
    chk(do_active_o == 1'b1, "R11", "loop armed", do_active_o, 1);
    chk(npc_sel_o == 2'd1 && target_o == 16'd81, "R11", "loop back", target_o, 81);

    // R1 reset in the middle of an armed loop
    @(negedge clk_i);
    idle(); valid_i = 1; pc_i = 16'd90; rep_start_i = 1; rep_count_i = 16'd5;
    @(negedge clk_i);
    idle();
    rst_ni = 1'b0;
    #1;
    chk(!do_active_o && !rep_active_o, "R1", "flags cleared by async reset",
        {do_active_o, rep_active_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    valid_i = 1; pc_i = 16'd81;
    #1;
    chk(npc_sel_o == 2'd0 && target_o == 16'd82, "R1", "no loop after reset", target_o, 82);
    chk(fetch_hold_o == 1'b0, "R1", "no hold after reset", fetch_hold_o, 0);

    @(negedge clk_i);
    idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule